// File: doc/BRIEF.md
# Pipelined Sine/Cosine Generator

This block turns an unsigned phase word into a pair of signed sine and cosine samples. The phase word spans one full turn. A new phase can be offered on every clock cycle, and each result leaves the block a fixed six cycles after its phase went in. The design is meant for direct digital synthesis, mixers and rotators that need a continuous stream of quadrature samples with no stalls.

The two top phase bits pick the quadrant. The next ten bits pick the nearest point of a quarter-wave sine table that holds 1025 entries and is computed at elaboration. The low eight bits form a signed residual measured from that point. A single table supplies the coarse sine at index i and the coarse cosine at index 1024−i through two read ports in the same cycle. The residual is scaled to radians by a fixed shift-and-add multiply by pi. Two parallel multiply-accumulates then apply a first-order slope correction. The results are rounded with saturation to 18-bit magnitudes. Finally the quadrant is restored using only swaps and negations, so the symmetry between the quadrants is exact to the bit.

Top module: `sincos_gen`

## Requirements
- R1: A phase presented with `phase_valid` high in cycle t produces `out_valid` high in cycle t+6 carrying that phase's result. Phases are accepted on consecutive cycles with no stall, and results leave in the same order.
- R2: A cycle with `phase_valid` low gives `out_valid` low six cycles later. While `out_valid` is low, `sin_out` and `cos_out` hold the last result that was delivered.
- R3: `sin_out` and `cos_out` are 18-bit two's complement values in the range −131071 to +131071. The value −131072 never appears.
- R4: For phase p, `sin_out` lies within 2 LSB of 131071·sin(2πp/2^20) rounded, and `cos_out` lies within 2 LSB of 131071·cos(2πp/2^20) rounded.
- R5: At the quarter points the outputs are exact: p=0x00000 gives (0, 131071), 0x40000 gives (131071, 0), 0x80000 gives (0, −131071) and 0xC0000 gives (−131071, 0), written as (sin, cos).
- R6: For every p, `cos_out`(p) equals `sin_out`(p+0x40000 mod 2^20) bit for bit, and `cos_out`(p+0x40000) equals −`sin_out`(p).
- R7: For every p, `sin_out`(p+0x80000 mod 2^20) equals −`sin_out`(p) and `cos_out`(p+0x80000) equals −`cos_out`(p), bit for bit.
- R8: Phase field layout: bits 19:18 are the quadrant, bits 17:8 are the table index, and bits 7:0 are the residual. When bit 7 is set, the index rounds up and the residual is negative. So phases one LSB from a quadrant boundary give exact values: 0x00001 gives (1, 131071), 0x3FFFF gives (131071, 1), 0x7FFFF gives (1, −131071), 0xBFFFF gives (−131071, −1) and 0xFFFFF gives (−1, 131071).
- R9: A synchronous active-high `rst` clears `out_valid`, `sin_out` and `cos_out` to zero and discards every phase in flight. After `rst` falls, the outputs stay zero with `out_valid` low until a new phase has passed through the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| phase_valid | input | 1 | Qualifies `phase_in` in this cycle |
| phase_in | input | 20 | Unsigned phase, one full turn per 2^20 |
| out_valid | output | 1 | `sin_out`/`cos_out` carry a new result |
| sin_out | output | 18 | Signed sine sample |
| cos_out | output | 18 | Signed cosine sample |

## Verification
The hardest cases to reach from the ports are the table end points. There the residual rounds the index up to 1024 and the cosine read lands on entry 0, so the whole cosine comes from the slope term alone. The stimulus reaches them by driving phases one LSB below and above each quadrant boundary, and by driving residuals of exactly 0x7F and 0x80. The exact symmetry is checked by sending each base phase back to back with its quarter-turn and half-turn shifts. The outputs of those related slots are then compared bit for bit. Idle slots are mixed into the stream, and a reset is applied while phases are in flight.

// File: rtl/sincos_pkg.sv
package sincos_pkg;

    typedef enum logic [1:0] {
        QUAD_0 = 2'd0,
        QUAD_1 = 2'd1,
        QUAD_2 = 2'd2,
        QUAD_3 = 2'd3
    } quad_e;

    localparam real PI_R     = 3.14159265358979323846;
    // pi as a fixed-point constant with PI_FRAC fraction bits, realised as shift-add
    localparam int  PI_FRAC  = 12;
    localparam int  PI_Q     = $rtoi(PI_R * 4096.0 + 0.5);

    // Quarter-wave sine point k of steps, scaled to amp, evaluated by Taylor series
    function automatic int quarter_sine(input int k, input int steps, input real amp);
        real x;
        real term;
        real acc;
        x    = real'(k) * PI_R / (2.0 * real'(steps));
        term = x;
        acc  = x;
        for (int n = 1; n < 12; n++) begin
            term = -term * x * x / (real'(2 * n) * real'(2 * n + 1));
            acc  = acc + term;
        end
        return $rtoi(acc * amp + 0.5);
    endfunction

endpackage

// File: rtl/sincos_quarter_rom.sv
module sincos_quarter_rom
    import sincos_pkg::*;
#(
    parameter int IDX_W = 10,
    parameter int TAB_W = 21,
    parameter int FULL  = 2097136
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en,
    input  logic [IDX_W:0]   idx,
    output logic [TAB_W-1:0] sin_q,
    output logic [TAB_W-1:0] cos_q
);
    localparam int POINTS = 2 ** IDX_W;
    localparam int DEPTH  = POINTS + 1;
    localparam int IW     = IDX_W + 1;

    logic [TAB_W-1:0] tbl [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_point
        localparam int VAL = quarter_sine(g, POINTS, real'(FULL));
        assign tbl[g] = TAB_W'(VAL);
    end

    logic [IDX_W:0] mirror_idx;
    assign mirror_idx = IW'(POINTS) - idx;

    always_ff @(posedge clk) begin
        if (rd_en) begin
            sin_q <= tbl[idx];
            cos_q <= tbl[mirror_idx];
        end
    end

    AST_ROM_ENDS: assert property (@(posedge clk) disable iff (rst)
        ($past(rd_en) && !$past(rst) && ($past(idx) == '0)) |->
        (sin_q == '0 && cos_q == TAB_W'(FULL))); // R5

endmodule

// File: rtl/sincos_interp.sv
module sincos_interp
    import sincos_pkg::*;
#(
    parameter int TAB_W   = 21,
    parameter int RP_W    = 23,
    parameter int OUT_W   = 18,
    parameter int GUARD_W = 4,
    parameter int D_SHIFT = 31
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid_i,
    input  quad_e            quad_i,
    input  logic [TAB_W-1:0] sb_i,
    input  logic [TAB_W-1:0] cb_i,
    input  logic signed [RP_W-1:0] rp_i,
    output logic             valid_o,
    output quad_e            quad_o,
    output logic [OUT_W-2:0] mag_s_o,
    output logic [OUT_W-2:0] mag_c_o
);
    localparam int PROD_W = TAB_W + 1 + RP_W;
    localparam int ACC_W  = TAB_W + 2;
    localparam logic signed [ACC_W-1:0] HALF   = ACC_W'(2 ** (GUARD_W - 1));
    localparam logic signed [ACC_W-1:0] MAXMAG = ACC_W'(2 ** (OUT_W - 1) - 1);

    typedef struct packed {
        logic  valid;
        quad_e quad;
    } tag_t;

    // stage A: slope products
    tag_t                     tag_a;
    logic [TAB_W-1:0]         sb_a, cb_a;
    logic signed [PROD_W-1:0] prod_s_a, prod_c_a;
    // stage B: accumulate
    tag_t                     tag_b;
    logic signed [ACC_W-1:0]  acc_s_b, acc_c_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_a <= '{valid: 1'b0, quad: QUAD_0};
            tag_b <= '{valid: 1'b0, quad: QUAD_0};
            valid_o <= 1'b0;
            quad_o  <= QUAD_0;
        end else begin
            tag_a   <= '{valid: valid_i, quad: quad_i};
            tag_b   <= tag_a;
            valid_o <= tag_b.valid;
            quad_o  <= tag_b.quad;
        end
    end

    function automatic logic [OUT_W-2:0] round_clip(input logic signed [ACC_W-1:0] v);
        logic signed [ACC_W-1:0] r;
        r = (v + HALF) >>> GUARD_W;
        if (r < 0)
            return '0;
        else if (r > MAXMAG)
            return (OUT_W-1)'(MAXMAG);
        else
            return (OUT_W-1)'(r);
    endfunction

    always_ff @(posedge clk) begin
        sb_a     <= sb_i;
        cb_a     <= cb_i;
        prod_s_a <= PROD_W'($signed({1'b0, cb_i})) * PROD_W'(rp_i);
        prod_c_a <= PROD_W'($signed({1'b0, sb_i})) * PROD_W'(rp_i);
        acc_s_b  <= ACC_W'($signed({1'b0, sb_a})) + ACC_W'(prod_s_a >>> D_SHIFT);
        acc_c_b  <= ACC_W'($signed({1'b0, cb_a})) - ACC_W'(prod_c_a >>> D_SHIFT);
        mag_s_o  <= round_clip(acc_s_b);
        mag_c_o  <= round_clip(acc_c_b);
    end

endmodule

// File: rtl/sincos_mirror.sv
module sincos_mirror
    import sincos_pkg::*;
#(
    parameter int OUT_W = 18
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    valid_i,
    input  quad_e                   quad_i,
    input  logic [OUT_W-2:0]        mag_s_i,
    input  logic [OUT_W-2:0]        mag_c_i,
    output logic                    valid_o,
    output logic signed [OUT_W-1:0] sin_o,
    output logic signed [OUT_W-1:0] cos_o
);
    localparam logic signed [OUT_W-1:0] MIN_CODE = {1'b1, {(OUT_W-1){1'b0}}};

    logic signed [OUT_W-1:0] ps, pc, sin_n, cos_n;

    always_comb begin
        ps = $signed({1'b0, mag_s_i});
        pc = $signed({1'b0, mag_c_i});
        unique case (quad_i)
            QUAD_0: begin sin_n = ps;  cos_n = pc;  end
            QUAD_1: begin sin_n = pc;  cos_n = -ps; end
            QUAD_2: begin sin_n = -ps; cos_n = -pc; end
            default: begin sin_n = -pc; cos_n = ps; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            sin_o   <= '0;
            cos_o   <= '0;
        end else begin
            valid_o <= valid_i;
            if (valid_i) begin
                sin_o <= sin_n;
                cos_o <= cos_n;
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (sin_o != MIN_CODE && cos_o != MIN_CODE)); // R3

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!valid_i && !$past(rst)) |=> ($stable(sin_o) && $stable(cos_o))); // R2

endmodule

// File: rtl/sincos_gen.sv
module sincos_gen
    import sincos_pkg::*;
#(
    parameter int PHASE_W = 20,
    parameter int OUT_W   = 18,
    parameter int IDX_W   = 10,
    parameter int GUARD_W = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    phase_valid,
    input  logic [PHASE_W-1:0]      phase_in,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] sin_out,
    output logic signed [OUT_W-1:0] cos_out
);
    localparam int RES_W   = PHASE_W - 2 - IDX_W;
    localparam int IW      = IDX_W + 1;
    localparam int TAB_W   = OUT_W - 1 + GUARD_W;
    localparam int FULL    = (2 ** (OUT_W - 1) - 1) * (2 ** GUARD_W);
    localparam int PI_W    = $clog2(PI_Q + 1);
    localparam int RP_W    = RES_W + PI_W + 1;
    localparam int D_SHIFT = PI_FRAC + PHASE_W - 1;
    localparam int LAT     = 6;
    localparam logic signed [OUT_W-1:0] MAX_OUT = OUT_W'(2 ** (OUT_W - 1) - 1);

    // stage 1: split phase, round index to nearest table point
    logic                    s1_valid;
    quad_e                   s1_quad;
    logic [IDX_W:0]          s1_idx;
    logic signed [RES_W-1:0] s1_res;

    always_ff @(posedge clk) begin
        if (rst) s1_valid <= 1'b0;
        else     s1_valid <= phase_valid;
        s1_quad <= quad_e'(phase_in[PHASE_W-1 -: 2]);
        s1_idx  <= {1'b0, phase_in[PHASE_W-3 -: IDX_W]} + IW'(phase_in[RES_W-1]);
        s1_res  <= $signed(phase_in[RES_W-1:0]);
    end

    // stage 2: table read and residual times pi by shift-add
    logic signed [RP_W-1:0] res_ext, rp_c, s2_rp;
    logic                   s2_valid;
    quad_e                  s2_quad;
    logic [TAB_W-1:0]       sin_base, cos_base;

    always_comb begin
        res_ext = RP_W'(s1_res);
        rp_c    = '0;
        for (int b = 0; b < PI_W; b++) begin
            if (PI_Q[b]) rp_c = rp_c + (res_ext <<< b);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s2_valid <= 1'b0;
        else     s2_valid <= s1_valid;
        s2_quad <= s1_quad;
        s2_rp   <= rp_c;
    end

    sincos_quarter_rom #(
        .IDX_W (IDX_W),
        .TAB_W (TAB_W),
        .FULL  (FULL)
    ) u_rom (
        .clk   (clk),
        .rst   (rst),
        .rd_en (s1_valid),
        .idx   (s1_idx),
        .sin_q (sin_base),
        .cos_q (cos_base)
    );

    // stages 3-5: slope correction, rounding
    logic             s5_valid;
    quad_e            s5_quad;
    logic [OUT_W-2:0] s5_mag_s, s5_mag_c;

    sincos_interp #(
        .TAB_W   (TAB_W),
        .RP_W    (RP_W),
        .OUT_W   (OUT_W),
        .GUARD_W (GUARD_W),
        .D_SHIFT (D_SHIFT)
    ) u_interp (
        .clk     (clk),
        .rst     (rst),
        .valid_i (s2_valid),
        .quad_i  (s2_quad),
        .sb_i    (sin_base),
        .cb_i    (cos_base),
        .rp_i    (s2_rp),
        .valid_o (s5_valid),
        .quad_o  (s5_quad),
        .mag_s_o (s5_mag_s),
        .mag_c_o (s5_mag_c)
    );

    // stage 6: quadrant restore
    sincos_mirror #(
        .OUT_W (OUT_W)
    ) u_mirror (
        .clk     (clk),
        .rst     (rst),
        .valid_i (s5_valid),
        .quad_i  (s5_quad),
        .mag_s_i (s5_mag_s),
        .mag_c_i (s5_mag_c),
        .valid_o (out_valid),
        .sin_o   (sin_out),
        .cos_o   (cos_out)
    );

    // cycles since reset, saturating at the pipeline depth
    logic [2:0] warm;
    always_ff @(posedge clk) begin
        if (rst)                   warm <= '0;
        else if (warm != 3'(LAT))  warm <= warm + 3'd1;
    end

    AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (warm == 3'(LAT)) |-> (out_valid == $past(phase_valid, LAT))); // R1

    AST_ZERO_PHASE: assert property (@(posedge clk) disable iff (rst)
        ((warm == 3'(LAT)) && $past(phase_valid && (phase_in == '0), LAT)) |->
        (sin_out == '0 && cos_out == MAX_OUT)); // R5

endmodule

// File: tb/sincos_gen_tb.sv
`timescale 1ns/1ps
module sincos_gen_tb;
    localparam int  LAT    = 6;
    localparam int  AMP    = 131071;
    localparam int  QTURN  = 1 << 18;
    localparam int  HTURN  = 1 << 19;
    localparam int  PMASK  = (1 << 20) - 1;
    localparam int  NB     = 100;
    localparam int  NSLOT  = 512;
    localparam real TWO_PI = 6.28318530717958647692;

    // phase, exact sin, exact cos, boundary-neighbour flag
    localparam int NVEC = 9;
    localparam int VEC_PH [NVEC] = '{32'h00000, 32'h40000, 32'h80000, 32'hC0000,
                                     32'h00001, 32'h3FFFF, 32'h7FFFF, 32'hBFFFF, 32'hFFFFF};
    localparam int VEC_S  [NVEC] = '{0, 131071, 0, -131071, 1, 131071, 1, -131071, -1};
    localparam int VEC_C  [NVEC] = '{131071, 0, -131071, 0, 131071, 1, -131071, -1, 131071};
    localparam bit VEC_ED [NVEC] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        phase_valid = 1'b0;
    logic [19:0] phase_in = '0;
    logic        out_valid;
    logic signed [17:0] sin_out, cos_out;

    int n_checks = 0;
    int n_errors = 0;
    int n_slots  = 0;
    int st_ph [NSLOT];
    bit st_v  [NSLOT];
    int got_s [NSLOT];
    int got_c [NSLOT];
    bit got_v [NSLOT];

    always #2.5 clk = ~clk;

    sincos_gen u_dut (
        .clk         (clk),
        .rst         (rst),
        .phase_valid (phase_valid),
        .phase_in    (phase_in),
        .out_valid   (out_valid),
        .sin_out     (sin_out),
        .cos_out     (cos_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ref_val(input int ph, input bit want_cos);
        real a, v;
        a = TWO_PI * real'(ph) / 1048576.0;
        v = real'(AMP) * (want_cos ? $cos(a) : $sin(a));
        return $rtoi(v >= 0.0 ? v + 0.5 : v - 0.5);
    endfunction

    function automatic int absi(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // drive slot c at negedge c, sample slot c-LAT at the same negedge first
    task automatic run_stream();
        for (int c = 0; c < n_slots + LAT; c++) begin
            @(negedge clk);
            if (c >= LAT) begin
                got_v[c-LAT] = out_valid;
                got_s[c-LAT] = int'(sin_out);
                got_c[c-LAT] = int'(cos_out);
            end
            if (c < n_slots) begin
                phase_valid = st_v[c];
                phase_in    = 20'(st_ph[c]);
            end else begin
                phase_valid = 1'b0;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        int seed;
        int base;
        // R9: reset state
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R9 valid in reset", int'(out_valid), 0);
        chk(sin_out == 0 && cos_out == 0, "R9 outputs in reset", int'(sin_out), 0);
        rst = 1'b0;

        // table of exact vectors, back to back (R5, R8, R1)
        n_slots = NVEC;
        for (int i = 0; i < NVEC; i++) begin
            st_ph[i] = VEC_PH[i];
            st_v[i]  = 1'b1;
        end
        run_stream();
        for (int i = 0; i < NVEC; i++) begin
            chk(got_v[i] == 1'b1, "R1 vector valid", int'(got_v[i]), 1);
            chk(got_s[i] == VEC_S[i], VEC_ED[i] ? "R8 sin" : "R5 sin", got_s[i], VEC_S[i]);
            chk(got_c[i] == VEC_C[i], VEC_ED[i] ? "R8 cos" : "R5 cos", got_c[i], VEC_C[i]);
        end

        // sweep: triples p, p+quarter, p+half, then a gap or extra phase
        seed = 32'h1234_5678;
        n_slots = 4 * NB;
        for (int i = 0; i < NB; i++) begin
            if (i < NVEC) base = VEC_PH[i];
            else if (i == NVEC)     base = 32'h20000;
            else if (i == NVEC + 1) base = 32'h3FF80;
            else if (i == NVEC + 2) base = 32'h0007F;
            else if (i == NVEC + 3) base = 32'h00080;
            else begin
                seed = seed * 1103515245 + 12345;
                base = (seed >>> 8) & PMASK;
            end
            st_ph[4*i]   = base;
            st_ph[4*i+1] = (base + QTURN) & PMASK;
            st_ph[4*i+2] = (base + HTURN) & PMASK;
            st_v[4*i]    = 1'b1;
            st_v[4*i+1]  = 1'b1;
            st_v[4*i+2]  = 1'b1;
            seed = seed * 1103515245 + 12345;
            st_ph[4*i+3] = (seed >>> 4) & PMASK;
            st_v[4*i+3]  = (i % 2) == 1;
        end
        run_stream();
        for (int k = 0; k < n_slots; k++) begin
            if (st_v[k]) begin
                chk(got_v[k] == 1'b1, "R1 stream valid", int'(got_v[k]), 1);
                chk(absi(got_s[k] - ref_val(st_ph[k], 1'b0)) <= 2, "R4 sin",
                    got_s[k], ref_val(st_ph[k], 1'b0));
                chk(absi(got_c[k] - ref_val(st_ph[k], 1'b1)) <= 2, "R4 cos",
                    got_c[k], ref_val(st_ph[k], 1'b1));
                chk(absi(got_s[k]) <= AMP && absi(got_c[k]) <= AMP, "R3 range",
                    got_s[k], AMP);
            end else begin
                chk(got_v[k] == 1'b0, "R2 idle slot", int'(got_v[k]), 0);
                chk(got_s[k] == got_s[k-1] && got_c[k] == got_c[k-1], "R2 hold",
                    got_s[k], got_s[k-1]);
            end
        end
        for (int i = 0; i < NB; i++) begin
            chk(got_c[4*i] == got_s[4*i+1], "R6 cos vs shifted sin", got_c[4*i], got_s[4*i+1]);
            chk(got_c[4*i+1] == -got_s[4*i], "R6 shifted cos", got_c[4*i+1], -got_s[4*i]);
            chk(got_s[4*i+2] == -got_s[4*i], "R7 sin half turn", got_s[4*i+2], -got_s[4*i]);
            chk(got_c[4*i+2] == -got_c[4*i], "R7 cos half turn", got_c[4*i+2], -got_c[4*i]);
        end

        // R9: reset with phases in flight
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            phase_valid = 1'b1;
            phase_in    = 20'h12345 + 20'(c);
        end
        @(negedge clk);
        phase_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0 && sin_out == 0 && cos_out == 0, "R9 reset clears",
            int'(sin_out), 0);
        rst = 1'b0;
        for (int c = 0; c < LAT + 1; c++) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R9 flushed valid", int'(out_valid), 0);
            chk(sin_out == 0 && cos_out == 0, "R9 flushed data", int'(cos_out), 0);
        end

        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule